// File: doc/BRIEF.md
# GPIO Pin Controller

This block drives and samples a bank of general-purpose pins under control of a simple register bus. Pins are grouped into ports. Every pin owns a small window of word registers in the address space. Software uses this window to enable the pin, choose its direction, set the level it drives, release the pad to float, set a millisecond debounce filter and read back the pad level.

Each pin also carries an event detector. The detector can watch for a level, a single edge of a chosen polarity, or both edges. It raises a per-pin status. Edge status is held until software clears it with a write, while level status simply follows the pad. The status, gated by a per-pin interrupt enable, drives one interrupt line per pin. Pad inputs pass through a two-flop synchroniser before any filtering, and the bus returns read data one cycle after the address.

Top module: `gpio_ctl`

## Requirements
- R1: Bus address decode. The pin at index p within port q has its window at byte address q*0x200 + p*0x20. Inside the window the word offsets are: 0x00 configuration (8 bits), 0x04 debounce threshold (8 bits), 0x08 input, 0x0C float control (bit 0), 0x10 output level (bit 0) and 0x14 event clear. Read data is registered and appears the cycle after the address. The clear word reads 0. An address with a port or pin past the bank, or an offset above 0x14, reads 0, and a write to it changes nothing.
- R2: Synchronous reset clears every register to 0, except the float bit of every pin, which resets to 1. After reset all pin_oe bits are low.
- R3: pin_oe for a pin is high exactly when configuration bit 0 (enable) and bit 1 (output direction) are both set and the float bit is clear. pin_out carries the output-level bit.
- R4: The input word's bit 0 depends on direction. When configuration bit 1 is set it returns the output-level bit. Otherwise it returns the filtered pad level, which trails pin_in by a two-flop synchroniser plus one filter register.
- R5: With configuration bit 5 set and a non-zero threshold T, the filtered level takes a new pad value only on the T-th ms_tick counted while the synchronised pad differs from it. Any return to the filtered value restarts the count. With bit 5 clear or T = 0 the filter is transparent.
- R6: Configuration bits 3:2 select the trigger. 0 gives no event. 1 is level. 2 is a single edge, where bit 4 set means rising and bit 4 clear means falling. 3 is both edges, and bit 4 is ignored.
- R7: In level mode the event is present while the filtered level equals bit 4 (1 = high, 0 = low). A clear write does not remove it.
- R8: In edge modes the event is held until a write of 1 in bit 0 of the clear word. Writing 0 there has no effect. An edge seen in the same cycle as the clear keeps the event set.
- R9: irq for a pin is its event ANDed with configuration bit 6.
- R10: Configuration bit 7 is stored and reads back but changes nothing else. With bit 0 clear, no edge or level event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write strobe |
| rdata | output | DATA_W | Read data, registered |
| ms_tick | input | 1 | One-cycle pulse each millisecond for debounce |
| pin_in | input | N_PORTS*PINS_PER_PORT | Pad levels |
| pin_out | output | N_PORTS*PINS_PER_PORT | Levels to drive on the pads |
| pin_oe | output | N_PORTS*PINS_PER_PORT | Pad drive enables |
| irq | output | N_PORTS*PINS_PER_PORT | Per-pin interrupt requests |

## Verification
The bench targets the cycle on which a clear write meets a fresh edge. A design that let the clear win would lose an interrupt there. It also runs a debounce glitch that returns to the old level just before the threshold; a filter that failed to restart its count would commit the glitch early. Addresses just past the last pin, port and offset are written and read. A decoder that wrapped or truncated fields would alias them onto a real pin and corrupt its configuration. Direction-dependent input reads, polarity being ignored in double-edge mode, and level events surviving a clear are also checked against a reference model every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_ONE   = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  // configuration word, bit 0 at the bottom
  typedef struct packed {
    logic  ts_flag;
    logic  irq_en;
    logic  db_en;
    logic  pol;
    trig_e trig;
    logic  dir_out;
    logic  en;
  } cfg_t;

  localparam int CFG_W = 8;

  // word index inside a pin window (byte offset / 4)
  localparam logic [2:0] W_CFG = 3'd0;
  localparam logic [2:0] W_DB  = 3'd1;
  localparam logic [2:0] W_IN  = 3'd2;
  localparam logic [2:0] W_FLT = 3'd3;
  localparam logic [2:0] W_OV  = 3'd4;
  localparam logic [2:0] W_CLR = 3'd5;

endpackage

// File: rtl/gpio_filter.sv
module gpio_filter #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pad,
  input  logic            tick,
  input  logic            db_en,
  input  logic [DB_W-1:0] thr,
  output logic            lvl
);

  logic            s1, s2;
  logic [DB_W-1:0] cnt;
  logic [DB_W:0]   cnt_nx;
  logic            db_on;

  assign db_on  = db_en && (thr != '0);
  assign cnt_nx = {1'b0, cnt} + {{DB_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      lvl <= 1'b0;
      cnt <= '0;
    end else begin
      s1 <= pad;
      s2 <= s1;
      if (!db_on) begin
        lvl <= s2;
        cnt <= '0;
      end else if (s2 == lvl) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt_nx >= {1'b0, thr}) begin
          lvl <= s2;
          cnt <= '0;
        end else begin
          cnt <= cnt_nx[DB_W-1:0];
        end
      end
    end
  end

  AST_DB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (db_on && !tick) |=> $stable(lvl)); // R5

endmodule

// File: rtl/gpio_event.sv
module gpio_event
  import gpio_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  lvl,
  input  logic  en,
  input  trig_e trig,
  input  logic  pol,
  input  logic  clr,
  output logic  st
);

  logic lvl_d, rise, fall, fire, edge_mode;

  assign rise      = lvl & ~lvl_d;
  assign fall      = ~lvl & lvl_d;
  assign edge_mode = (trig == TRIG_ONE) || (trig == TRIG_BOTH);

  always_comb begin
    case (trig)
      TRIG_ONE:  fire = en & (pol ? rise : fall);
      TRIG_BOTH: fire = en & (rise | fall);
      default:   fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d <= 1'b0;
      st    <= 1'b0;
    end else begin
      lvl_d <= lvl;
      case (trig)
        TRIG_OFF:   st <= 1'b0;
        TRIG_LEVEL: st <= en & (lvl == pol);
        default: begin
          if (fire)     st <= 1'b1;
          else if (clr) st <= 1'b0;
        end
      endcase
    end
  end

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && st && !clr) |=> st); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && st && clr && !fire) |=> !st); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (trig == TRIG_OFF) |=> !st); // R6

endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_pkg::*;
#(
  parameter int DB_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        word,
  input  logic [CFG_W-1:0]  wd,
  input  logic              pad,
  input  logic              tick,
  output logic              oe,
  output logic              dout,
  output logic              req,
  output logic [DATA_W-1:0] rword
);

  cfg_t            cfg;
  logic [DB_W-1:0] thr;
  logic            flt, ov, lvl, st, clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
      thr <= '0;
      flt <= 1'b1;
      ov  <= 1'b0;
    end else if (wr) begin
      case (word)
        W_CFG:   cfg <= cfg_t'(wd);
        W_DB:    thr <= wd[DB_W-1:0];
        W_FLT:   flt <= wd[0];
        W_OV:    ov  <= wd[0];
        default: ;
      endcase
    end
  end

  assign clr = wr && (word == W_CLR) && wd[0];

  gpio_filter #(.DB_W(DB_W)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .pad   (pad),
    .tick  (tick),
    .db_en (cfg.db_en),
    .thr   (thr),
    .lvl   (lvl)
  );

  gpio_event u_evt (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl),
    .en   (cfg.en),
    .trig (cfg.trig),
    .pol  (cfg.pol),
    .clr  (clr),
    .st   (st)
  );

  assign oe   = cfg.en & cfg.dir_out & ~flt;
  assign dout = ov;
  assign req  = st & cfg.irq_en;

  always_comb begin
    rword = '0;
    case (word)
      W_CFG:   rword[CFG_W-1:0] = cfg;
      W_DB:    rword[DB_W-1:0]  = thr;
      W_IN:    rword[0]         = cfg.dir_out ? ov : lvl;
      W_FLT:   rword[0]         = flt;
      W_OV:    rword[0]         = ov;
      default: ;
    endcase
  end

endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
  import gpio_pkg::*;
#(
  parameter int N_PORTS       = 2,
  parameter int PINS_PER_PORT = 4,
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32,
  parameter int DB_W          = 8,
  localparam int N_PINS       = N_PORTS * PINS_PER_PORT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  input  logic              ms_tick,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] irq
);

  localparam int PORT_W = ADDR_W - 9;

  logic [PORT_W-1:0] a_port;
  logic [3:0]        a_pin;
  logic [2:0]        a_word;
  logic              hit;
  logic [N_PINS-1:0] sel;
  logic [DATA_W-1:0] rword [N_PINS];
  logic [DATA_W-1:0] rd_nx;
  logic              unused_bits;

  assign a_port = addr[ADDR_W-1:9];
  assign a_pin  = addr[8:5];
  assign a_word = addr[4:2];
  assign hit    = (int'(a_port) < N_PORTS) && (int'(a_pin) < PINS_PER_PORT)
                  && (a_word <= W_CLR);
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CFG_W]};

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign sel[i] = hit && (int'(a_port) == i / PINS_PER_PORT)
                        && (int'(a_pin) == i % PINS_PER_PORT);
    gpio_pin #(.DB_W(DB_W), .DATA_W(DATA_W)) u_pin (
      .clk   (clk),
      .rst   (rst),
      .wr    (we && sel[i]),
      .word  (a_word),
      .wd    (wdata[CFG_W-1:0]),
      .pad   (pin_in[i]),
      .tick  (ms_tick),
      .oe    (pin_oe[i]),
      .dout  (pin_out[i]),
      .req   (irq[i]),
      .rword (rword[i])
    );
  end

  always_comb begin
    rd_nx = '0;
    for (int i = 0; i < N_PINS; i++) begin
      if (sel[i]) rd_nx = rword[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (rdata == '0)); // R1
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel)); // R1

endmodule

// File: tb/sim_gpio_ctl.sv
module sim_gpio_ctl;

  localparam int NP = 2;
  localparam int PP = 4;
  localparam int N  = NP * PP;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic         we = 1'b0;
  logic [31:0]  rdata;
  logic         ms_tick = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, irq;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  gpio_ctl u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .ms_tick(ms_tick), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cfg[N], m_thr[N], m_flt[N], m_ov[N];
  int m_s1[N], m_s2[N], m_lv[N], m_lvd[N], m_cnt[N], m_st[N];
  int m_rd;

  function automatic int m_idx(int a);
    int port = a >> 9;
    int pin  = (a >> 5) & 15;
    int w    = (a >> 2) & 7;
    if (port < NP && pin < PP && w <= 5) return port * PP + pin;
    return -1;
  endfunction

  function automatic int m_read(int k, int w);
    case (w)
      0: return m_cfg[k];
      1: return m_thr[k];
      2: return ((m_cfg[k] >> 1) & 1) != 0 ? m_ov[k] : m_lv[k];
      3: return m_flt[k];
      4: return m_ov[k];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int a, k, w;
    a = int'(addr);
    k = m_idx(a);
    w = (a >> 2) & 7;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_cfg[i] = 0; m_thr[i] = 0; m_flt[i] = 1; m_ov[i] = 0;
        m_s1[i] = 0; m_s2[i] = 0; m_lv[i] = 0; m_lvd[i] = 0;
        m_cnt[i] = 0; m_st[i] = 0;
      end
      m_rd = 0;
    end else begin
      m_rd = (k < 0) ? 0 : m_read(k, w);
      for (int i = 0; i < N; i++) begin
        int typ, pol, en, rise, fall, clr, db;
        typ  = (m_cfg[i] >> 2) & 3;
        pol  = (m_cfg[i] >> 4) & 1;
        en   = m_cfg[i] & 1;
        db   = (m_cfg[i] >> 5) & 1;
        rise = (m_lv[i] == 1 && m_lvd[i] == 0) ? 1 : 0;
        fall = (m_lv[i] == 0 && m_lvd[i] == 1) ? 1 : 0;
        clr  = (we && k == i && w == 5 && wdata[0]) ? 1 : 0;
        if (typ == 0) m_st[i] = 0;
        else if (typ == 1) m_st[i] = (en == 1 && m_lv[i] == pol) ? 1 : 0;
        else if (en == 1 && ((typ == 3 && (rise || fall)) ||
                             (typ == 2 && ((pol == 1) ? rise : fall) == 1)))
          m_st[i] = 1;
        else if (clr == 1) m_st[i] = 0;
        m_lvd[i] = m_lv[i];
        if (db == 0 || m_thr[i] == 0) begin
          m_lv[i] = m_s2[i]; m_cnt[i] = 0;
        end else if (m_s2[i] == m_lv[i]) begin
          m_cnt[i] = 0;
        end else if (ms_tick) begin
          if (m_cnt[i] + 1 >= m_thr[i]) begin
            m_lv[i] = m_s2[i]; m_cnt[i] = 0;
          end else m_cnt[i] = m_cnt[i] + 1;
        end
        m_s2[i] = m_s1[i];
        m_s1[i] = int'(pin_in[i]);
      end
      if (we && k >= 0) begin
        case (w)
          0: m_cfg[k] = int'(wdata[7:0]);
          1: m_thr[k] = int'(wdata[7:0]);
          3: m_flt[k] = int'(wdata[0]);
          4: m_ov[k]  = int'(wdata[0]);
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        chk("R3 pin_oe model", int'(pin_oe[i]),
            ((m_cfg[i] & 3) == 3 && m_flt[i] == 0) ? 1 : 0);
        chk("R3 pin_out model", int'(pin_out[i]), m_ov[i]);
        chk("R9 irq model", int'(irq[i]),
            (m_st[i] == 1 && ((m_cfg[i] >> 6) & 1) == 1) ? 1 : 0);
      end
      chk("R1 rdata model", int'(rdata), m_rd);
    end
  end

  // ---------------- stimulus ----------------
  function automatic int pa(int i);
    return ((i / PP) << 9) | ((i % PP) << 5);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    addr = 12'(a); wdata = 32'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, string tag, int exp);
    addr = 12'(a);
    @(negedge clk);
    chk(tag, int'(rdata), exp);
  endtask

  task automatic tick1();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_all();
    cyc(3);
    rst = 1'b0;
    cyc(2);
    // R2 reset state
    rd(pa(0) + 'h0C, "R2 float reset", 1);
    rd(pa(5), "R2 cfg reset", 0);
    chk("R2 pin_oe reset", int'(pin_oe), 0);
    // R1 map, readback, unmapped
    wr(pa(6), 'h1A5);
    rd(pa(6), "R1 cfg readback", 'hA5);
    wr(pa(6), 0);
    wr(pa(6) + 4, 'h3C);
    rd(pa(6) + 4, "R1 debounce readback", 'h3C);
    wr(2 << 9, 'hFF);
    rd(2 << 9, "R1 unmapped port", 0);
    wr(pa(1) + 'h18, 'hFF);
    rd(pa(1) + 'h18, "R1 unmapped offset", 0);
    rd(pa(1), "R1 no alias", 0);
    wr(5 << 5, 'hFF);
    rd(5 << 5, "R1 unmapped pin", 0);
    rd(pa(5), "R1 no alias pin", 0);
    // R3 drive
    wr(pa(0) + 'h10, 1);
    wr(pa(0), 3);
    chk("R3 floated", int'(pin_oe[0]), 0);
    wr(pa(0) + 'h0C, 0);
    chk("R3 driven oe", int'(pin_oe[0]), 1);
    chk("R3 driven level", int'(pin_out[0]), 1);
    wr(pa(0), 1);
    chk("R3 input dir", int'(pin_oe[0]), 0);
    // R4 input read
    wr(pa(1), 1);
    pin_in[1] = 1'b1;
    rd(pa(1) + 8, "R4 sync latency", 0);
    cyc(3);
    rd(pa(1) + 8, "R4 pad read", 1);
    wr(pa(1) + 'h10, 0);
    wr(pa(1), 3);
    rd(pa(1) + 8, "R4 output read", 0);
    wr(pa(1) + 'h10, 1);
    rd(pa(1) + 8, "R4 output read hi", 1);
    // R5 debounce
    wr(pa(2) + 4, 3);
    wr(pa(2), 'h21);
    pin_in[2] = 1'b1;
    cyc(5);
    rd(pa(2) + 8, "R5 no ticks", 0);
    tick1(); tick1();
    rd(pa(2) + 8, "R5 two ticks", 0);
    tick1();
    rd(pa(2) + 8, "R5 third tick", 1);
    pin_in[2] = 1'b0;
    cyc(3);
    tick1(); tick1();
    pin_in[2] = 1'b1;
    cyc(3);
    pin_in[2] = 1'b0;
    cyc(3);
    tick1(); tick1();
    rd(pa(2) + 8, "R5 glitch restart", 1);
    tick1();
    rd(pa(2) + 8, "R5 commit", 0);
    // R6 / R8 / R9 edges on pin 3
    wr(pa(3), 'h59);
    pin_in[3] = 1'b1; cyc(5);
    chk("R6 rising", int'(irq[3]), 1);
    pin_in[3] = 1'b0; cyc(5);
    chk("R8 held", int'(irq[3]), 1);
    wr(pa(3) + 'h14, 0);
    chk("R8 clear zero", int'(irq[3]), 1);
    wr(pa(3) + 'h14, 1);
    chk("R8 cleared", int'(irq[3]), 0);
    wr(pa(3), 'h49);
    pin_in[3] = 1'b1; cyc(5);
    chk("R6 falling ignores rise", int'(irq[3]), 0);
    pin_in[3] = 1'b0; cyc(5);
    chk("R6 falling", int'(irq[3]), 1);
    wr(pa(3) + 'h14, 1);
    wr(pa(3), 'h4D);
    pin_in[3] = 1'b1; cyc(5);
    chk("R6 both rise", int'(irq[3]), 1);
    wr(pa(3) + 'h14, 1);
    chk("R6 both cleared", int'(irq[3]), 0);
    pin_in[3] = 1'b0; cyc(5);
    chk("R6 both fall", int'(irq[3]), 1);
    wr(pa(3) + 'h14, 1);
    wr(pa(3), 'h41);
    pin_in[3] = 1'b1; cyc(5);
    pin_in[3] = 1'b0; cyc(5);
    chk("R6 none", int'(irq[3]), 0);
    // R8 clear meets edge
    wr(pa(3), 'h59);
    pin_in[3] = 1'b1; cyc(5);
    pin_in[3] = 1'b0; cyc(5);
    pin_in[3] = 1'b1; cyc(3);
    wr(pa(3) + 'h14, 1);
    chk("R8 edge beats clear", int'(irq[3]), 1);
    // R9 gate
    wr(pa(3), 'h19);
    chk("R9 masked", int'(irq[3]), 0);
    wr(pa(3), 'h59);
    chk("R9 unmasked", int'(irq[3]), 1);
    wr(pa(3) + 'h14, 1);
    // R7 level on pin 4
    wr(pa(4), 'h55);
    cyc(5);
    chk("R7 level high idle", int'(irq[4]), 0);
    pin_in[4] = 1'b1; cyc(5);
    chk("R7 level high", int'(irq[4]), 1);
    wr(pa(4) + 'h14, 1);
    cyc(1);
    chk("R7 clear ignored", int'(irq[4]), 1);
    pin_in[4] = 1'b0; cyc(5);
    chk("R7 level drops", int'(irq[4]), 0);
    wr(pa(4), 'h45);
    cyc(2);
    chk("R7 level low", int'(irq[4]), 1);
    // R10 flag and enable
    wr(pa(5), 'hD9);
    rd(pa(5), "R10 flag readback", 'hD9);
    pin_in[5] = 1'b1; cyc(5);
    chk("R10 flag inert", int'(irq[5]), 1);
    wr(pa(5) + 'h14, 1);
    wr(pa(5), 'hD8);
    pin_in[5] = 1'b0; cyc(5);
    pin_in[5] = 1'b1; cyc(5);
    chk("R10 disabled pin", int'(irq[5]), 0);
    cyc(4);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R1 watchdog got=hung exp=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule